// File: doc/BRIEF.md
# Paged program counter branch unit

This block holds the program counter of a small 4-bit controller and resolves its branch instructions. The counter has two parts: a page number and an address inside the page. Each clock the block takes one 10-bit instruction word, which is the word fetched from the current counter value. It then registers the next fetch address. Most words simply step the in-page address.

Three branch forms are recognised. The near jump is one word and rewrites only the in-page address. The far jump is two words: the first carries the lower five page bits and the second carries the two upper page bits and the in-page target. The computed jump is also two words: the first is a fixed opcode and the second carries the full page number. Its in-page target comes from the low three bits of the D register, used as the upper part, and the 4-bit accumulator, used as the lower part. Both operands arrive on input ports.

After the first word of a two-word form, the block marks a pending state. It commits the target when the second word arrives on the next cycle. While the first word executes, the counter steps so that the second word can be fetched.

Top module: `pc_branch_unit`

## Requirements
- R1: A synchronous active-high reset sets page and in-page address to 0 and drops any pending two-word branch, so the word after reset is decoded afresh.
- R2: A word that is not a branch, and is not the second word of a two-word branch, adds 1 to the 7-bit in-page address. The address wraps from 127 to 0 and the page is left unchanged.
- R3: A near jump, whose bits [9:7] are 011, loads bits [6:0] into the in-page address on the next clock and keeps the page.
- R4: A far-jump first word, whose bits [9:5] are 00111, stores bits [4:0] as the low page bits and otherwise advances the counter as in R2.
- R5: The word after a far-jump first word sets the page to {bits [8:7], stored low page bits} and the in-page address to bits [6:0].
- R6: A computed-jump first word, exactly 0x010, advances the counter as in R2.
- R7: The word after a computed-jump first word sets the page to {bits [8:6], bits [3:0]} and the in-page address to {D[2:0], A[3:0]}, with D and A taken in that same cycle.
- R8: The word after any first word is always used as the second word, even if its pattern would decode as a branch. The word that follows it is decoded normally.
- R9: The accumulator and D inputs affect nothing except on the second word of a computed jump.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| insn_word | input | 10 | Instruction word fetched at the current address |
| acc_in | input | 4 | Accumulator value |
| dreg_in | input | 3 | Low bits of the D register |
| fetch_page | output | 7 | Registered page part of the fetch address |
| fetch_low | output | 7 | Registered in-page part of the fetch address |

## Verification
A bad pending flag or a bad stored page field shows at the ports one clock after the second word: the page, the in-page address, or both come out wrong. A pending state that never clears, or one that is set without cause, shows on the following word, which then fails to step or to jump. Comparing both outputs on every clock against a behavioural model therefore catches these faults within one or two cycles. The comparison covers page 127, address 127, wrap-around, resets in mid-branch, and second words that look like opcodes.

// File: rtl/pcb_pkg.sv
package pcb_pkg;
  localparam int INSN_W  = 10;
  localparam int PAGE_W  = 7;
  localparam int LOW_W   = 7;
  localparam int ACC_W   = 4;
  localparam int DREG_W  = 3;
  localparam int PLO_W   = 5;

  typedef enum logic [1:0] {
    PEND_NONE     = 2'd0,
    PEND_FAR      = 2'd1,
    PEND_COMPUTED = 2'd2
  } pend_e;
endpackage

// File: rtl/pcb_decode.sv
module pcb_decode
  import pcb_pkg::*;
#(
  parameter int W = INSN_W
) (
  input  logic [W-1:0] insn,
  input  pend_e        pend,
  output logic         second,
  output logic         near_jump,
  output logic         far_first,
  output logic         calc_first
);
  localparam logic [2:0] NEAR_OP = 3'b011;
  localparam logic [4:0] FAR_OP  = 5'b00111;
  localparam logic [W-1:0] CALC_OP = W'(10'h010);

  always_comb begin
    second     = (pend != PEND_NONE);
    near_jump  = !second && (insn[W-1 -: 3] == NEAR_OP);
    far_first  = !second && (insn[W-1 -: 5] == FAR_OP);
    calc_first = !second && (insn == CALC_OP);
  end
endmodule

// File: rtl/pcb_long_track.sv
module pcb_long_track
  import pcb_pkg::*;
#(
  parameter int PW = PLO_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          far_first,
  input  logic          calc_first,
  input  logic          second,
  input  logic [PW-1:0] plo_field,
  output pend_e         pend,
  output logic [PW-1:0] plo_saved
);
  always_ff @(posedge clk) begin
    if (rst) begin
      pend      <= PEND_NONE;
      plo_saved <= '0;
    end else if (far_first) begin
      pend      <= PEND_FAR;
      plo_saved <= plo_field;
    end else if (calc_first) begin
      pend      <= PEND_COMPUTED;
    end else if (second) begin
      pend      <= PEND_NONE;
    end
  end

  AST_PEND_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    (pend != PEND_NONE) |=> (pend == PEND_NONE)); // R8
  AST_FIRST_SETS_PEND: assert property (@(posedge clk) disable iff (rst)
    (far_first || calc_first) |=> (pend != PEND_NONE)); // R4
endmodule

// File: rtl/pcb_counter.sv
module pcb_counter
  import pcb_pkg::*;
#(
  parameter int PGW = PAGE_W,
  parameter int LW  = LOW_W,
  parameter int AW  = ACC_W,
  parameter int DW  = DREG_W
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           second,
  input  logic           near_jump,
  input  pend_e          pend,
  input  logic [PGW-1:0] far_page,
  input  logic [PGW-1:0] calc_page,
  input  logic [LW-1:0]  word_low,
  input  logic [AW-1:0]  acc,
  input  logic [DW-1:0]  dreg,
  output logic [PGW-1:0] page_q,
  output logic [LW-1:0]  low_q
);
  logic [PGW-1:0] page_n;
  logic [LW-1:0]  low_n;

  always_comb begin
    page_n = page_q;
    low_n  = low_q + 1'b1;
    if (second) begin
      if (pend == PEND_FAR) begin
        page_n = far_page;
        low_n  = word_low;
      end else begin
        page_n = calc_page;
        low_n  = LW'({dreg, acc});
      end
    end else if (near_jump) begin
      low_n = word_low;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      page_q <= '0;
      low_q  <= '0;
    end else begin
      page_q <= page_n;
      low_q  <= low_n;
    end
  end

  AST_RESET_ZERO: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (page_q == '0 && low_q == '0)); // R1
  AST_STEP_WRAPS: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(second) && !$past(near_jump))
      |-> (low_q == LW'($past(low_q) + 1'b1) && page_q == $past(page_q))); // R2
  AST_NEAR_KEEPS_PAGE: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(near_jump))
      |-> (low_q == $past(word_low) && page_q == $past(page_q))); // R3
  AST_FAR_TARGET: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(second) && $past(pend) == PEND_FAR)
      |-> (page_q == $past(far_page) && low_q == $past(word_low))); // R5
  AST_CALC_TARGET: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(second) && $past(pend) == PEND_COMPUTED)
      |-> (page_q == $past(calc_page) && low_q == LW'({$past(dreg), $past(acc)}))); // R7
endmodule

// File: rtl/pc_branch_unit.sv
module pc_branch_unit
  import pcb_pkg::*;
#(
  parameter int IW  = INSN_W,
  parameter int PGW = PAGE_W,
  parameter int LW  = LOW_W,
  parameter int AW  = ACC_W,
  parameter int DW  = DREG_W
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [IW-1:0]  insn_word,
  input  logic [AW-1:0]  acc_in,
  input  logic [DW-1:0]  dreg_in,
  output logic [PGW-1:0] fetch_page,
  output logic [LW-1:0]  fetch_low
);
  localparam int PLW = PLO_W;

  logic           second, near_jump, far_first, calc_first;
  pend_e          pend;
  logic [PLW-1:0] plo_saved;
  logic [PGW-1:0] far_page, calc_page;
  logic [LW-1:0]  word_low;

  assign word_low  = insn_word[LW-1:0];
  assign far_page  = {insn_word[8:7], plo_saved};
  assign calc_page = {insn_word[8:6], insn_word[3:0]};

  pcb_decode #(.W(IW)) u_dec (
    .insn       (insn_word),
    .pend       (pend),
    .second     (second),
    .near_jump  (near_jump),
    .far_first  (far_first),
    .calc_first (calc_first)
  );

  pcb_long_track #(.PW(PLW)) u_track (
    .clk        (clk),
    .rst        (rst),
    .far_first  (far_first),
    .calc_first (calc_first),
    .second     (second),
    .plo_field  (insn_word[PLW-1:0]),
    .pend       (pend),
    .plo_saved  (plo_saved)
  );

  pcb_counter #(.PGW(PGW), .LW(LW), .AW(AW), .DW(DW)) u_pc (
    .clk        (clk),
    .rst        (rst),
    .second     (second),
    .near_jump  (near_jump),
    .pend       (pend),
    .far_page   (far_page),
    .calc_page  (calc_page),
    .word_low   (word_low),
    .acc        (acc_in),
    .dreg       (dreg_in),
    .page_q     (fetch_page),
    .low_q      (fetch_low)
  );
endmodule

// File: tb/pc_branch_unit_tb.sv
module pc_branch_unit_tb;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [9:0] insn_word = '0;
  logic [3:0] acc_in = '0;
  logic [2:0] dreg_in = '0;
  logic [6:0] fetch_page, fetch_low;

  int n_checks = 0;
  int n_fails  = 0;

  int         m_page = 0, m_low = 0, m_pend = 0;
  logic [4:0] m_plo = '0;

  always #10 clk = ~clk;

  pc_branch_unit u_dut (
    .clk(clk), .rst(rst), .insn_word(insn_word), .acc_in(acc_in),
    .dreg_in(dreg_in), .fetch_page(fetch_page), .fetch_low(fetch_low)
  );

  task automatic model(input logic [9:0] w, input logic [3:0] a,
                       input logic [2:0] d, input logic r);
    if (r) begin
      m_page = 0; m_low = 0; m_pend = 0;
    end else if (m_pend == 1) begin
      m_page = w[8:7] * 32 + m_plo;
      m_low  = w[6:0];
      m_pend = 0;
    end else if (m_pend == 2) begin
      m_page = w[8:6] * 16 + w[3:0];
      m_low  = d * 16 + a;
      m_pend = 0;
    end else if (w[9:7] == 3'b011) begin
      m_low = w[6:0];
    end else if (w[9:5] == 5'b00111) begin
      m_plo = w[4:0]; m_pend = 1; m_low = (m_low + 1) % 128;
    end else if (w == 10'h010) begin
      m_pend = 2; m_low = (m_low + 1) % 128;
    end else begin
      m_low = (m_low + 1) % 128;
    end
  endtask

  task automatic step(input logic [9:0] w, input logic [3:0] a,
                      input logic [2:0] d, input logic r, input string tag);
    insn_word = w; acc_in = a; dreg_in = d; rst = r;
    model(w, a, d, r);
    @(negedge clk);
    n_checks++;
    if (fetch_page !== 7'(m_page) || fetch_low !== 7'(m_low)) begin
      n_fails++;
      $display("FAIL %s: page/low got %0d/%0d expected %0d/%0d",
               tag, fetch_page, fetch_low, m_page, m_low);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
    $finish;
  end

  initial begin
    @(negedge clk);
    step(10'h000, 4'h0, 3'h0, 1'b1, "R1 reset");
    step(10'h000, 4'h0, 3'h0, 1'b1, "R1 reset");
    // R2: plain words across the 127->0 wrap, R9: operands toggle
    for (int i = 0; i < 130; i++)
      step(10'h200 + 10'(i % 64), 4'(i), 3'(i), 1'b0, "R2 R9 step");
    // R3: near jump to 127, then wrap
    step(10'b011_1111111, 4'hF, 3'h7, 1'b0, "R3 near 127");
    step(10'h001, 4'h0, 3'h0, 1'b0, "R2 wrap after near");
    // R4 R5: far jump to page 127 / addr 127
    step(10'b00111_11111, 4'h3, 3'h1, 1'b0, "R4 far first");
    step(10'b1_11_1111111, 4'h3, 3'h1, 1'b0, "R5 far to 127/127");
    step(10'h005, 4'h0, 3'h0, 1'b0, "R2 page kept after far");
    // R6 R7: computed jump with D=7, A=15
    step(10'h010, 4'h2, 3'h2, 1'b0, "R6 calc first");
    step(10'b1_111_00_1111, 4'hF, 3'h7, 1'b0, "R7 calc to 127/127");
    step(10'h010, 4'h0, 3'h0, 1'b0, "R6 calc first");
    step(10'b1_010_00_0101, 4'h9, 3'h3, 1'b0, "R7 calc page 37");
    // R8: second word that looks like a far first word
    step(10'b00111_00001, 4'h0, 3'h0, 1'b0, "R4 far first");
    step(10'h0E3, 4'h0, 3'h0, 1'b0, "R8 opcode-like second");
    step(10'b011_0000010, 4'h0, 3'h0, 1'b0, "R8 next word decoded");
    step(10'h010, 4'h0, 3'h0, 1'b0, "R6 calc first");
    step(10'h010, 4'h6, 3'h5, 1'b0, "R8 second equal to 0x010");
    step(10'h100, 4'h0, 3'h0, 1'b0, "R8 decoded normally");
    // R1: reset while a far jump is pending
    step(10'b00111_10101, 4'h0, 3'h0, 1'b0, "R4 far first");
    step(10'h000, 4'h0, 3'h0, 1'b1, "R1 reset mid branch");
    step(10'b011_0011001, 4'h0, 3'h0, 1'b0, "R1 fresh decode after reset");
    // mixed stream
    for (int i = 0; i < 400; i++) begin
      logic [9:0] w;
      int k = int'($urandom % 8);
      case (k)
        0: w = {3'b011, 7'($urandom)};
        1: w = {5'b00111, 5'($urandom)};
        2: w = 10'h010;
        default: w = 10'($urandom);
      endcase
      step(w, 4'($urandom), 3'($urandom), ($urandom % 60) == 0, "R2 R3 R5 R7 R9 mixed");
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
    $finish;
  end
endmodule